// File: doc/BRIEF.md
# Timing-Wheel Cell Resequencer

This block restores timestamp order to cells that leave a multistage switch fabric out of order. Each arriving cell carries a small handle (its buffer index elsewhere) and the time it entered the fabric. The block compares that stamp with a shared time counter. It parks the handle in a slot of a wheel of linked lists, chosen by the time at which the cell's age will equal a fixed limit. Every cycle the slot of the current time is spliced whole onto a ready list, which drains through a valid/ready output port. One buffer serves all sources of one output, and each cell costs a fixed amount of work: one append and, later, one splice and one pop.

A parameter chooses how late cells are handled. In strict mode, any cell older than the limit is dropped. In loose mode the wheel is twice as large. A cell that is late by less than one limit is parked at its stamp plus twice the limit, and only cells older than twice the limit are dropped. Drops are reported by a pulse and a wrapping counter. Payload storage and time distribution are handled elsewhere.

Top module: `cell_reseq_wheel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid is 0 and drop_count is 0.
- R2: A cell with age a = (now - in_ts) mod 2^TS_W below AGE_LIMIT is presented on the output starting in the cycle after the one in which now equals in_ts + AGE_LIMIT, and not before.
- R3: Handles leave in order of their release time. Cells with the same release time leave in arrival order, and cells already parked leave before a cell that passes straight through.
- R4: A cell that arrives with age exactly AGE_LIMIT is placed on the ready list at once. If the slot due in that same cycle holds cells, they are spliced first and the new cell follows them.
- R5: In strict mode (LOOSE=0), every arrival with age above AGE_LIMIT is dropped. This includes stamps ahead of now, which wrap to large ages.
- R6: In loose mode (LOOSE=1), an arrival with age strictly between AGE_LIMIT and 2*AGE_LIMIT is held until now equals in_ts + 2*AGE_LIMIT. One with age exactly 2*AGE_LIMIT passes straight to the ready list, and one with age above 2*AGE_LIMIT is dropped.
- R7: drop_pulse is high in the same cycle as a dropped arrival. drop_count then rises by one (mod 2^CNT_W) at that clock edge and stays unchanged in cycles without a drop.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_handle keeps its value. A handle is removed only at an edge where both are 1.
- R9: Every arrival that is not dropped appears on the output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now | input | TS_W | Shared time counter; advances by one per cycle |
| in_valid | input | 1 | An arrival is present this cycle |
| in_handle | input | HANDLE_W | Handle of the arriving cell; not in flight |
| in_ts | input | TS_W | Fabric entry time of the arriving cell |
| out_valid | output | 1 | A ready handle is presented |
| out_ready | input | 1 | Consumer takes the presented handle |
| out_handle | output | HANDLE_W | Oldest ready handle |
| drop_pulse | output | 1 | The arrival of this cycle is discarded |
| drop_count | output | CNT_W | Wrapping count of discarded arrivals |

## Verification
The bench feeds one stimulus to a strict and a loose instance and predicts the release order of each from the age rules. It aims at a cell reaching the limit in the very cycle its slot drains: a design that gave the arrival priority would emit it ahead of older cells, and one that parked it would hold it for a whole wheel turn. Ages straddling the limit, twice the limit and wrapped future stamps probe the classifier, where an off-by-one would drop a cell that should be kept or keep one that should be dropped. Stalls on out_ready while splices and direct arrivals land on the ready list expose a lost link or a head that moves under backpressure. Both show up as missing, duplicated or reordered handles.

// File: rtl/reseq_pkg.sv
// Shared definitions for the timing-wheel resequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package reseq_pkg;

    // Fate of one arrival, decided from its age
    typedef enum logic [1:0] {
        ARR_IDLE = 2'd0,   // no arrival this cycle
        ARR_PARK = 2'd1,   // append to a future wheel slot
        ARR_PASS = 2'd2,   // due now: append to the ready list
        ARR_DROP = 2'd3    // too old: discard
    } arr_kind_e;

    // Wheel size: a power of two strictly above the longest forward distance
    function automatic int wheel_slots(input int limit, input bit loose);
        int span;
        span = loose ? (2 * limit + 1) : (limit + 1);
        return 1 << $clog2(span);
    endfunction

endpackage

// File: rtl/reseq_classify.sv
// Decides what happens to an arriving cell from its age (now - stamp).
// Ages below the limit park at stamp+limit, age equal to the limit passes
// straight through; in loose mode a second window parks at stamp+2*limit.
// Assumes: 2*AGE_LIMIT < 2**TS_W and SLOTS exceeds every forward distance.
module reseq_classify
    import reseq_pkg::*;
#(
    parameter int TS_W      = 8,
    parameter int AGE_LIMIT = 6,
    parameter bit LOOSE     = 1'b0,
    parameter int SLOT_W    = 3
) (
    input  logic [TS_W-1:0]   now,
    input  logic              in_valid,
    input  logic [TS_W-1:0]   in_ts,
    output arr_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [TS_W-1:0] LIM = TS_W'(AGE_LIMIT);

    logic [TS_W-1:0]   age;
    logic [SLOT_W-1:0] due_on;
    logic [SLOT_W-1:0] due_late;
    logic              late_park;
    logic              late_pass;

    assign age    = now - in_ts;
    assign due_on = in_ts[SLOT_W-1:0] + SLOT_W'(AGE_LIMIT);

    // Mode variant: the loose policy adds a second window of ages
    generate
        if (LOOSE) begin : g_loose
            localparam logic [TS_W-1:0] LIM2 = TS_W'(2 * AGE_LIMIT);
            assign late_park = (age > LIM) && (age < LIM2);
            assign late_pass = (age == LIM2);
            assign due_late  = in_ts[SLOT_W-1:0] + SLOT_W'(2 * AGE_LIMIT);
        end else begin : g_strict
            assign late_park = 1'b0;
            assign late_pass = 1'b0;
            assign due_late  = due_on;
        end
    endgenerate

    // Purpose: map the age onto park, pass or drop
    always_comb begin
        kind = ARR_IDLE;
        slot = due_on;
        if (in_valid) begin
            if (age < LIM) begin
                kind = ARR_PARK;
            end else if (age == LIM) begin
                kind = ARR_PASS;
            end else if (late_park) begin
                kind = ARR_PARK;
                slot = due_late;
            end else if (late_pass) begin
                kind = ARR_PASS;
            end else begin
                kind = ARR_DROP;
            end
        end
    end

endmodule

// File: rtl/reseq_wheel.sv
// Wheel of per-slot linked lists: head, tail and an occupied flag per slot.
// Appends one handle per cycle and exposes the slot due for release, which
// is emptied at the same edge. Link writes go out to the shared link memory.
// Assumes: the append slot never equals the release slot.
module reseq_wheel #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3,
    parameter int HW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_en,
    input  logic [SLOT_W-1:0] app_slot,
    input  logic [HW-1:0]     app_handle,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              rel_v,
    output logic [HW-1:0]     rel_head,
    output logic [HW-1:0]     rel_tail,
    output logic              lnk_we,
    output logic [HW-1:0]     lnk_addr,
    output logic [HW-1:0]     lnk_data
);

    logic [HW-1:0]    head_q [SLOTS];
    logic [HW-1:0]    tail_q [SLOTS];
    logic [SLOTS-1:0] used_q;

    // Purpose: clear the released slot and mark the appended one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            used_q[rel_slot] <= 1'b0;
            if (app_en) used_q[app_slot] <= 1'b1;
        end
    end

    // Purpose: move the tail, and the head too when the slot was empty
    always_ff @(posedge clk) begin
        if (app_en) begin
            tail_q[app_slot] <= app_handle;
            if (!used_q[app_slot]) head_q[app_slot] <= app_handle;
        end
    end

    // Purpose: expose the released slot and the link from the old tail
    always_comb begin
        rel_v    = used_q[rel_slot];
        rel_head = head_q[rel_slot];
        rel_tail = tail_q[rel_slot];
        lnk_we   = app_en && used_q[app_slot];
        lnk_addr = tail_q[app_slot];
        lnk_data = app_handle;
    end

    // A parked cell must wait at least one cycle (R2)
    assert_no_collide_R2: assert property (@(posedge clk) disable iff (!rst_n)
        app_en |-> (app_slot != rel_slot));

endmodule

// File: rtl/reseq_link_mem.sv
// Next-handle memory shared by the wheel lists and the ready list.
// Two write ports and one asynchronous read port.
// Assumes: the two ports never write the same handle in one cycle.
module reseq_link_mem #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [HW-1:0] addr_a,
    input  logic [HW-1:0] data_a,
    input  logic          we_b,
    input  logic [HW-1:0] addr_b,
    input  logic [HW-1:0] data_b,
    input  logic [HW-1:0] rd_addr,
    output logic [HW-1:0] rd_data
);

    localparam int DEPTH = 1 << HW;

    logic [HW-1:0] next_q [DEPTH];

    // Purpose: store up to two links per cycle
    always_ff @(posedge clk) begin
        if (we_a) next_q[addr_a] <= data_a;
        if (we_b) next_q[addr_b] <= data_b;
    end

    assign rd_data = next_q[rd_addr];

    // Two links in one cycle belong to distinct cells (R9)
    assert_link_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (addr_a != addr_b));

endmodule

// File: rtl/reseq_ready_list.sv
// Ready list with valid/ready output. Each cycle it pops the head if taken,
// then appends the released slot segment and after it a pass-through cell.
// Assumes: link memory reads are asynchronous and reflect earlier edges.
module reseq_ready_list #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spl_v,
    input  logic [HW-1:0] spl_head,
    input  logic [HW-1:0] spl_tail,
    input  logic          dir_v,
    input  logic [HW-1:0] dir_handle,
    input  logic          out_ready,
    input  logic [HW-1:0] head_next,
    output logic [HW-1:0] rd_addr,
    output logic          out_valid,
    output logic [HW-1:0] out_handle,
    output logic          tail_we,
    output logic [HW-1:0] tail_addr,
    output logic [HW-1:0] tail_data,
    output logic          inner_we,
    output logic [HW-1:0] inner_addr,
    output logic [HW-1:0] inner_data
);

    logic          live_q;
    logic [HW-1:0] head_q;
    logic [HW-1:0] tail_q;

    logic          pop;
    logic          rem_v;
    logic [HW-1:0] rem_head;
    logic          seg_v;
    logic [HW-1:0] seg_head;
    logic [HW-1:0] seg_tail;
    logic          nxt_v;
    logic [HW-1:0] nxt_head;
    logic [HW-1:0] nxt_tail;

    assign out_valid  = live_q;
    assign out_handle = head_q;
    assign rd_addr    = head_q;

    // Purpose: list left after the pop
    always_comb begin
        pop      = live_q && out_ready;
        rem_v    = live_q && !(pop && (head_q == tail_q));
        rem_head = pop ? head_next : head_q;
    end

    // Purpose: build the segment appended this cycle, splice before pass-through
    always_comb begin
        seg_v      = spl_v || dir_v;
        seg_head   = spl_v ? spl_head : dir_handle;
        seg_tail   = dir_v ? dir_handle : spl_tail;
        inner_we   = spl_v && dir_v;
        inner_addr = spl_tail;
        inner_data = dir_handle;
    end

    // Purpose: join the segment to the remaining list
    always_comb begin
        nxt_v     = rem_v || seg_v;
        tail_addr = tail_q;
        tail_data = seg_head;
        if (rem_v) begin
            nxt_head = rem_head;
            nxt_tail = seg_v ? seg_tail : tail_q;
            tail_we  = seg_v;
        end else begin
            nxt_head = seg_head;
            nxt_tail = seg_tail;
            tail_we  = 1'b0;
        end
    end

    // Purpose: occupancy flag under reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= nxt_v;
    end

    // Purpose: list pointers, meaningful only while the list is live
    always_ff @(posedge clk) begin
        head_q <= nxt_head;
        tail_q <= nxt_tail;
    end

    // Backpressure holds the presented handle (R8)
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_handle)));

endmodule

// File: rtl/cell_reseq_wheel.sv
// Timing-wheel cell resequencer top. Classifies each arrival by age, parks
// it in a wheel slot or passes it to the ready list, releases the slot of
// the current time every cycle and counts discarded late cells.
// Assumes: now advances by one per cycle; handles are unique while in flight.
module cell_reseq_wheel
    import reseq_pkg::*;
#(
    parameter int TS_W      = 8,
    parameter int HANDLE_W  = 5,
    parameter int AGE_LIMIT = 6,
    parameter bit LOOSE     = 1'b0,
    parameter int CNT_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     now,
    input  logic                in_valid,
    input  logic [HANDLE_W-1:0] in_handle,
    input  logic [TS_W-1:0]     in_ts,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [HANDLE_W-1:0] out_handle,
    output logic                drop_pulse,
    output logic [CNT_W-1:0]    drop_count
);

    localparam int SLOTS  = wheel_slots(AGE_LIMIT, LOOSE);
    localparam int SLOT_W = $clog2(SLOTS);

    arr_kind_e             kind;
    logic [SLOT_W-1:0]     park_slot;
    logic                  rel_v;
    logic [HANDLE_W-1:0]   rel_head;
    logic [HANDLE_W-1:0]   rel_tail;
    logic                  w_we;
    logic [HANDLE_W-1:0]   w_addr;
    logic [HANDLE_W-1:0]   w_data;
    logic                  t_we;
    logic [HANDLE_W-1:0]   t_addr;
    logic [HANDLE_W-1:0]   t_data;
    logic                  i_we;
    logic [HANDLE_W-1:0]   i_addr;
    logic [HANDLE_W-1:0]   i_data;
    logic [HANDLE_W-1:0]   rd_addr;
    logic [HANDLE_W-1:0]   rd_data;
    logic [CNT_W-1:0]      drops_q;

    reseq_classify #(
        .TS_W(TS_W), .AGE_LIMIT(AGE_LIMIT), .LOOSE(LOOSE), .SLOT_W(SLOT_W)
    ) u_classify (
        .now(now), .in_valid(in_valid), .in_ts(in_ts),
        .kind(kind), .slot(park_slot)
    );

    reseq_wheel #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .HW(HANDLE_W)
    ) u_wheel (
        .clk(clk), .rst_n(rst_n),
        .app_en(kind == ARR_PARK), .app_slot(park_slot), .app_handle(in_handle),
        .rel_slot(now[SLOT_W-1:0]),
        .rel_v(rel_v), .rel_head(rel_head), .rel_tail(rel_tail),
        .lnk_we(w_we), .lnk_addr(w_addr), .lnk_data(w_data)
    );

    reseq_ready_list #(
        .HW(HANDLE_W)
    ) u_ready (
        .clk(clk), .rst_n(rst_n),
        .spl_v(rel_v), .spl_head(rel_head), .spl_tail(rel_tail),
        .dir_v(kind == ARR_PASS), .dir_handle(in_handle),
        .out_ready(out_ready), .head_next(rd_data), .rd_addr(rd_addr),
        .out_valid(out_valid), .out_handle(out_handle),
        .tail_we(t_we), .tail_addr(t_addr), .tail_data(t_data),
        .inner_we(i_we), .inner_addr(i_addr), .inner_data(i_data)
    );

    // Wheel appends and splice-to-pass links never occur in the same cycle
    reseq_link_mem #(
        .HW(HANDLE_W)
    ) u_links (
        .clk(clk), .rst_n(rst_n),
        .we_a(t_we), .addr_a(t_addr), .data_a(t_data),
        .we_b(w_we || i_we),
        .addr_b(w_we ? w_addr : i_addr),
        .data_b(w_we ? w_data : i_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign drop_pulse = (kind == ARR_DROP);
    assign drop_count = drops_q;

    // Purpose: wrapping count of discarded arrivals
    always_ff @(posedge clk) begin
        if (!rst_n)          drops_q <= '0;
        else if (drop_pulse) drops_q <= drops_q + 1'b1;
    end

    // Each drop adds exactly one (R7)
    assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> (drop_count == $past(drop_count) + 1'b1));

    // No drop, no change (R7)
    assert_drop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_pulse |=> $stable(drop_count));

    // A released slot always lands on the output (R3)
    assert_release_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rel_v |=> out_valid);

endmodule

// File: tb/cell_reseq_wheel_bench.sv
// Scoreboard bench: one stimulus drives a strict and a loose instance; the
// driver task predicts each instance's release order, monitors compare.
module cell_reseq_wheel_bench;

    localparam int TS_W = 8;
    localparam int HW   = 5;
    localparam int LIM  = 6;
    localparam int CW   = 8;
    localparam int NH   = 1 << HW;

    typedef struct { int h; int st; } exp_t;
    typedef struct { int h; int rel; } pend_t;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [TS_W-1:0] now;
    logic            in_valid;
    logic [HW-1:0]   in_handle;
    logic [TS_W-1:0] in_ts;
    logic            out_ready;
    logic            ov [2];
    logic [HW-1:0]   oh [2];
    logic            dp [2];
    logic [CW-1:0]   dc [2];

    exp_t  exp_q  [2][$];
    pend_t pend_q [2][$];
    bit    busy   [2][NH];
    int    exp_drops [2];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    nxt_h = 0;
    int    seed = 7;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cell_reseq_wheel #(.TS_W(TS_W), .HANDLE_W(HW), .AGE_LIMIT(LIM), .LOOSE(1'b0), .CNT_W(CW))
    u_cell_reseq_wheel (
        .clk(clk), .rst_n(rst_n), .now(now), .in_valid(in_valid),
        .in_handle(in_handle), .in_ts(in_ts), .out_valid(ov[0]),
        .out_ready(out_ready), .out_handle(oh[0]), .drop_pulse(dp[0]),
        .drop_count(dc[0])
    );

    cell_reseq_wheel #(.TS_W(TS_W), .HANDLE_W(HW), .AGE_LIMIT(LIM), .LOOSE(1'b1), .CNT_W(CW))
    u_cell_reseq_wheel_loose (
        .clk(clk), .rst_n(rst_n), .now(now), .in_valid(in_valid),
        .in_handle(in_handle), .in_ts(in_ts), .out_valid(ov[1]),
        .out_ready(out_ready), .out_handle(oh[1]), .drop_pulse(dp[1]),
        .drop_count(dc[1])
    );

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32767;
    endfunction

    // Reference model of one instance for the current value of now
    task automatic model(input int m, input bit v, input int h, input int ts, output bit dropped);
        int i;
        int age;
        exp_t e;
        pend_t p;
        dropped = 1'b0;
        i = 0;
        while (i < pend_q[m].size()) begin
            if (pend_q[m][i].rel == int'(now)) begin
                e.h = pend_q[m][i].h; e.st = cyc;
                exp_q[m].push_back(e);
                pend_q[m].delete(i);
            end else begin
                i++;
            end
        end
        if (v) begin
            age = (int'(now) - ts) & 255;
            p.h = h; e.h = h; e.st = cyc;
            if (age < LIM) begin                                   // R2
                p.rel = (ts + LIM) & 255; pend_q[m].push_back(p); busy[m][h] = 1'b1;
            end else if (age == LIM) begin                         // R4
                exp_q[m].push_back(e); busy[m][h] = 1'b1;
            end else if (m == 1 && age < 2 * LIM) begin            // R6
                p.rel = (ts + 2 * LIM) & 255; pend_q[m].push_back(p); busy[m][h] = 1'b1;
            end else if (m == 1 && age == 2 * LIM) begin           // R6
                exp_q[m].push_back(e); busy[m][h] = 1'b1;
            end else begin                                         // R5 / R6
                dropped = 1'b1;
                exp_drops[m]++;
            end
        end
    endtask

    // Driver: one cycle of stimulus and prediction
    task automatic step(input bit v, input int age, input bit rdy, output int got);
        bit ok;
        bit d0;
        bit d1;
        int ts;
        @(negedge clk);
        now = now + 8'd1;
        out_ready = rdy;
        ok = 1'b0;
        got = -1;
        if (v) begin
            for (int k = 0; k < NH; k++) begin
                int idx;
                idx = (nxt_h + k) % NH;
                if (!ok && !busy[0][idx] && !busy[1][idx]) begin
                    got = idx; ok = 1'b1;
                end
            end
        end
        ts = (int'(now) - age) & 255;
        in_valid  = ok;
        in_handle = ok ? got[HW-1:0] : '0;
        in_ts     = ts[TS_W-1:0];
        model(0, ok, got, ts, d0);
        model(1, ok, got, ts, d1);
        if (ok) nxt_h = (got + 1) % NH;
        #1;
        checks += 2;
        if (dp[0] !== d0) begin
            errors++;
            $display("FAIL R5 R7 strict drop_pulse actual=%0b expected=%0b age=%0d", dp[0], d0, age);
        end
        if (dp[1] !== d1) begin
            errors++;
            $display("FAIL R6 R7 loose drop_pulse actual=%0b expected=%0b age=%0d", dp[1], d1, age);
        end
    endtask

    // Monitor: compare output handshakes with the predicted queue
    task automatic watch(input int m);
        logic          pv;
        logic [HW-1:0] ph;
        pv = 1'b0; ph = '0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                pv = 1'b0;
                continue;
            end
            if (pv) begin                                          // R8
                checks++;
                if (ov[m] !== 1'b1 || oh[m] !== ph) begin
                    errors++;
                    $display("FAIL R8 inst%0d hold actual=%0b/%0d expected=1/%0d", m, ov[m], oh[m], ph);
                end
            end
            if (ov[m] === 1'b1) begin
                checks++;
                if (exp_q[m].size() == 0) begin
                    errors++;
                    $display("FAIL R2 inst%0d early output actual=%0d expected=none", m, oh[m]);
                end else begin
                    if (exp_q[m][0].h != int'(oh[m])) begin        // R3
                        errors++;
                        $display("FAIL R3 inst%0d order actual=%0d expected=%0d", m, oh[m], exp_q[m][0].h);
                    end
                    if (out_ready) begin
                        busy[m][exp_q[m][0].h] = 1'b0;
                        void'(exp_q[m].pop_front());
                    end
                end
            end else if (exp_q[m].size() > 0 && exp_q[m][0].st < cyc) begin
                checks++;
                errors++;
                $display("FAIL R2 inst%0d late output actual=idle expected=%0d", m, exp_q[m][0].h);
            end
            pv = ov[m] && !out_ready;
            ph = oh[m];
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ha;
        int hb;
        int dummy;
        rst_n = 1'b0; now = 8'd240; in_valid = 1'b0; in_handle = '0;
        in_ts = '0; out_ready = 1'b1;
        exp_drops[0] = 0; exp_drops[1] = 0;
        fork
            watch(0);
            watch(1);
        join_none
        repeat (3) @(negedge clk);
        #1;
        for (int m = 0; m < 2; m++) begin                          // R1
            checks++;
            if (ov[m] !== 1'b0 || dc[m] !== '0) begin
                errors++;
                $display("FAIL R1 inst%0d reset actual=%0b/%0d expected=0/0", m, ov[m], dc[m]);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // In-order arrivals, age zero (R2)
        for (int i = 0; i < 10; i++) step(1'b1, 0, 1'b1, dummy);
        for (int i = 0; i < 2 * LIM + 4; i++) step(1'b0, 0, 1'b1, dummy);

        // R4: slot drains in the cycle a limit-aged cell arrives
        step(1'b1, 0, 1'b1, ha);
        for (int i = 0; i < LIM - 1; i++) step(1'b0, 0, 1'b1, dummy);
        step(1'b1, LIM, 1'b1, hb);
        step(1'b0, 0, 1'b1, dummy);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (ov[m] !== 1'b1 || int'(oh[m]) != ha) begin
                errors++;
                $display("FAIL R4 inst%0d first actual=%0d expected=%0d", m, oh[m], ha);
            end
        end
        step(1'b0, 0, 1'b1, dummy);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (ov[m] !== 1'b1 || int'(oh[m]) != hb) begin
                errors++;
                $display("FAIL R4 inst%0d second actual=%0d expected=%0d", m, oh[m], hb);
            end
        end

        // Late and future ages around the limits (R5, R6)
        step(1'b1, LIM + 1, 1'b1, dummy);
        step(1'b1, LIM + 3, 1'b1, dummy);
        step(1'b1, 2 * LIM - 1, 1'b0, dummy);
        step(1'b1, 2 * LIM, 1'b0, dummy);
        step(1'b1, 2 * LIM + 1, 1'b1, dummy);
        step(1'b1, 200, 1'b1, dummy);
        step(1'b1, 1, 1'b0, dummy);
        for (int i = 0; i < 2 * LIM + 4; i++) step(1'b0, 0, (i % 3) != 0, dummy);

        // Mixed ages with backpressure (R3, R8, R9)
        for (int i = 0; i < 400; i++) begin
            int a;
            a = (rnd() % 16 == 0) ? 128 + (rnd() % 100) : rnd() % (2 * LIM + 4);
            step((rnd() % 2) == 1, a, (rnd() % 4) != 0, dummy);
        end

        // Drain
        for (int i = 0; i < 3 * LIM + 40; i++) step(1'b0, 0, 1'b1, dummy);
        for (int m = 0; m < 2; m++) begin
            checks++;                                              // R9
            if (exp_q[m].size() != 0 || pend_q[m].size() != 0 || ov[m] !== 1'b0) begin
                errors++;
                $display("FAIL R9 inst%0d leftover actual=%0d/%0d expected=0/0", m,
                         exp_q[m].size(), pend_q[m].size());
            end
            checks++;                                              // R7
            if (int'(dc[m]) != (exp_drops[m] & 255)) begin
                errors++;
                $display("FAIL R7 inst%0d drop_count actual=%0d expected=%0d", m, dc[m], exp_drops[m] & 255);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule